// File: doc/BRIEF.md
# Banked Memory Mapper with Boot ROM Overlay

This block lets a processor with a 64 KB address space reach a 512 KB RAM and a 1 MB ROM. It does this by generating the physical address lines above bit 14 for each memory. The lower fifteen address lines go straight from the processor to both memories and do not pass through the block. Two byte-wide configuration registers set the bank choice. A port decoder outside the block writes them with one-cycle write strobes, and both registers take their value from the shared data bus.

The lower 32 KB window can be banked. The RAM register selects one of sixteen RAM banks for that window. The ROM register selects one of thirty-two 32 KB ROM slices for it. The upper 32 KB window always maps to the top RAM region, whatever the RAM register holds. This keeps resident system software in place.

After reset, both registers hold zero. In that state the ROM overlays the lower window, so execution starts from ROM at address 0. Software switches the overlay off by setting the overlay flag in the RAM register. After that, RAM covers all 64 KB. The block drives the active-low chip selects for both memories from the memory request strobe.

Top module: `bank_mapper`

## Requirements
- R1: While `rst_n` is low at a clock edge, both registers are cleared to zero. With `cpu_a15`=0, this gives `ram_bank`=0 and `rom_bank`=0, and the ROM overlay is active.
- R2: The RAM register captures `data_in` on a rising clock edge when `ram_cfg_wr` is 1. Bits 3:0 are the RAM bank, and bit 7 is the overlay-off flag (0 = ROM overlaid). The register keeps its value while `ram_cfg_wr` is 0.
- R3: The ROM register captures `data_in` bits 4:0 on a rising clock edge when `rom_cfg_wr` is 1, and keeps its value otherwise. `rom_bank` always equals the stored value, independent of `cpu_a15`.
- R4: When `cpu_a15` is 1, `ram_bank` is 4'hF regardless of the RAM register.
- R5: When `cpu_a15` is 0, `ram_bank` equals RAM register bits 3:0.
- R6: `rom_cs_n` is 0 exactly when `mreq_n` is 0, `cpu_a15` is 0 and the overlay flag is 0.
- R7: `ram_cs_n` is 0 exactly when `mreq_n` is 0 and the condition of R6 does not hold.
- R8: When `mreq_n` is 1, both chip selects are 1. The two chip selects are never 0 at the same time.
- R9: A register write takes effect on the outputs only after the clock edge that samples the strobe. During the strobe cycle the outputs still reflect the old value. A write to both registers in the same cycle loads each of them from the same `data_in` byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_a15 | input | 1 | Processor address bit 15 |
| mreq_n | input | 1 | Active-low memory request |
| data_in | input | 8 | Processor data bus |
| ram_cfg_wr | input | 1 | One-cycle write strobe for the RAM register |
| rom_cfg_wr | input | 1 | One-cycle write strobe for the ROM register |
| ram_bank | output | 4 | RAM physical address lines 18..15 |
| rom_bank | output | 5 | ROM physical address lines 19..15 |
| ram_cs_n | output | 1 | Active-low RAM chip select |
| rom_cs_n | output | 1 | Active-low ROM chip select |

## Verification
A configuration write and a live memory decode can fall in the same cycle. The bench provokes this by raising a write strobe while `mreq_n` is low in the lower window. It checks the selects and bank lines before the edge, expecting the old mapping, and again one cycle later, expecting the new mapping. The bench also writes both registers in one cycle, and it asserts reset during a pending write to confirm that the clear wins.

// File: rtl/mapper_pkg.sv
// Package: shared widths and field positions of the bank mapper.
// Assumes an 8-bit data bus; the RAM register keeps the bank in its low
// bits and the overlay-off flag in a single high bit.
package mapper_pkg;
    localparam int DATA_W      = 8;
    localparam int RAM_BANK_W  = 4;
    localparam int ROM_BANK_W  = 5;
    localparam int OVERLAY_BIT = 7;
    localparam int RAM_REG_W   = RAM_BANK_W + 1;

    typedef struct packed {
        logic                  overlay_off;
        logic [RAM_BANK_W-1:0] bank;
    } ram_cfg_t;
endpackage

// File: rtl/cfg_latch.sv
// Module: cfg_latch
// A parameterised configuration register. It loads d on a rising edge when wr
// is high, holds otherwise, and returns to RESET_VAL under synchronous
// active-low reset. Assumes wr is a single-cycle strobe synchronous to clk.
module cfg_latch #(
    parameter int             W         = 4,
    parameter logic [W-1:0]   RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Register update: reset has priority over a pending write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RESET_VAL;
        else if (wr)
            q <= d;
    end
endmodule

// File: rtl/bank_steer.sv
// Module: bank_steer
// Drives the RAM upper address lines. In the upper half of the CPU space each
// line is forced high, so it always reaches the top RAM region. In the lower
// half the stored bank passes through. Purely combinational.
module bank_steer #(
    parameter int W = 4
) (
    input  logic         cpu_a15,
    input  logic [W-1:0] bank,
    output logic [W-1:0] phys_hi
);
    // One forcing gate per physical address line.
    for (genvar i = 0; i < W; i++) begin : g_line
        assign phys_hi[i] = bank[i] | cpu_a15;
    end
endmodule

// File: rtl/select_decode.sv
// Module: select_decode
// Generates the active-low memory chip selects. ROM is chosen for a lower-half
// request while the overlay is on; every other request goes to RAM. Both
// selects are idle without a memory request. Purely combinational.
module select_decode (
    input  logic mreq_n,
    input  logic cpu_a15,
    input  logic overlay_off,
    output logic ram_cs_n,
    output logic rom_cs_n
);
    logic rom_hit;

    // Decide which memory owns the current request.
    always_comb begin
        rom_hit  = !cpu_a15 && !overlay_off;
        rom_cs_n = !(!mreq_n && rom_hit);
        ram_cs_n = !(!mreq_n && !rom_hit);
    end
endmodule

// File: rtl/bank_mapper.sv
// Module: bank_mapper (top)
// Maps a 64 KB CPU space onto banked RAM and ROM. Two configuration registers,
// written by one-cycle strobes from an external port decoder, supply the
// upper physical address lines. The top RAM region stays pinned in the upper
// window, and ROM overlays the lower window after reset. Assumes strobes and
// address inputs are synchronous to clk; reset is synchronous, active low.
module bank_mapper
    import mapper_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_a15,
    input  logic                  mreq_n,
    input  logic [DATA_W-1:0]     data_in,
    input  logic                  ram_cfg_wr,
    input  logic                  rom_cfg_wr,
    output logic [RAM_BANK_W-1:0] ram_bank,
    output logic [ROM_BANK_W-1:0] rom_bank,
    output logic                  ram_cs_n,
    output logic                  rom_cs_n
);
    ram_cfg_t              ram_cfg_d;
    ram_cfg_t              ram_cfg_q;
    logic [RAM_REG_W-1:0]  ram_cfg_bits;
    logic                  unused_data;

    // Gather the RAM register fields from the data bus.
    always_comb begin
        ram_cfg_d.overlay_off = data_in[OVERLAY_BIT];
        ram_cfg_d.bank        = data_in[RAM_BANK_W-1:0];
    end

    // Bus bits that no register field uses.
    assign unused_data = ^data_in;

    cfg_latch #(.W(RAM_REG_W), .RESET_VAL('0)) u_ram_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (ram_cfg_wr),
        .d     (ram_cfg_d),
        .q     (ram_cfg_bits)
    );

    assign ram_cfg_q = ram_cfg_bits;

    cfg_latch #(.W(ROM_BANK_W), .RESET_VAL('0)) u_rom_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (rom_cfg_wr),
        .d     (data_in[ROM_BANK_W-1:0]),
        .q     (rom_bank)
    );

    bank_steer #(.W(RAM_BANK_W)) u_steer (
        .cpu_a15 (cpu_a15),
        .bank    (ram_cfg_q.bank),
        .phys_hi (ram_bank)
    );

    select_decode u_sel (
        .mreq_n      (mreq_n),
        .cpu_a15     (cpu_a15),
        .overlay_off (ram_cfg_q.overlay_off),
        .ram_cs_n    (ram_cs_n),
        .rom_cs_n    (rom_cs_n)
    );
endmodule

// File: rtl/bank_mapper_chk.sv
// Module: bank_mapper_chk
// Port-level checker for bank_mapper, attached with bind below.
module bank_mapper_chk
    import mapper_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cpu_a15,
    input logic                  mreq_n,
    input logic [DATA_W-1:0]     data_in,
    input logic                  ram_cfg_wr,
    input logic                  rom_cfg_wr,
    input logic [RAM_BANK_W-1:0] ram_bank,
    input logic [ROM_BANK_W-1:0] rom_bank,
    input logic                  ram_cs_n,
    input logic                  rom_cs_n
);
    // R8: no request, no select
    p_idle_selects_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_n |-> (ram_cs_n && rom_cs_n));

    // R8: selects mutually exclusive
    p_exclusive_selects_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ram_cs_n && !rom_cs_n));

    // R4: upper window pinned to top RAM region
    p_upper_pinned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_a15 |-> (ram_bank == '1));

    // R7: upper-window request always goes to RAM
    p_upper_is_ram_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mreq_n && cpu_a15) |-> (!ram_cs_n && rom_cs_n));

    // R3: ROM bank loads from the bus on a strobe
    p_rom_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rom_cfg_wr |=> (rom_bank == $past(data_in[ROM_BANK_W-1:0])));

    // R3: ROM bank holds without a strobe
    p_rom_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_cfg_wr |=> $stable(rom_bank));
endmodule

bind bank_mapper bank_mapper_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_a15    (cpu_a15),
    .mreq_n     (mreq_n),
    .data_in    (data_in),
    .ram_cfg_wr (ram_cfg_wr),
    .rom_cfg_wr (rom_cfg_wr),
    .ram_bank   (ram_bank),
    .rom_bank   (rom_bank),
    .ram_cs_n   (ram_cs_n),
    .rom_cs_n   (rom_cs_n)
);

// File: tb/bank_mapper_test.sv
// Bench for bank_mapper: table-driven mapping checks, then directed tests.
module bank_mapper_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_a15 = 1'b0;
    logic       mreq_n = 1'b1;
    logic [7:0] data_in = 8'h00;
    logic       ram_cfg_wr = 1'b0;
    logic       rom_cfg_wr = 1'b0;
    logic [3:0] ram_bank;
    logic [4:0] rom_bank;
    logic       ram_cs_n;
    logic       rom_cs_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bank_mapper uut (
        .clk(clk), .rst_n(rst_n), .cpu_a15(cpu_a15), .mreq_n(mreq_n),
        .data_in(data_in), .ram_cfg_wr(ram_cfg_wr), .rom_cfg_wr(rom_cfg_wr),
        .ram_bank(ram_bank), .rom_bank(rom_bank),
        .ram_cs_n(ram_cs_n), .rom_cs_n(rom_cs_n)
    );

    // {ram_val, rom_val, a15, mreq_n, exp_ram_bank, exp_rom_bank, exp_ram_cs_n, exp_rom_cs_n}
    localparam int NV = 10;
    localparam logic [28:0] VEC [NV] = '{
        {8'h00, 8'h00, 1'b0, 1'b0, 4'h0, 5'h00, 1'b1, 1'b0},
        {8'h00, 8'h00, 1'b1, 1'b0, 4'hF, 5'h00, 1'b0, 1'b1},
        {8'hFF, 8'hFF, 1'b0, 1'b0, 4'hF, 5'h1F, 1'b0, 1'b1},
        {8'hFF, 8'hFF, 1'b1, 1'b0, 4'hF, 5'h1F, 1'b0, 1'b1},
        {8'h05, 8'h13, 1'b0, 1'b0, 4'h5, 5'h13, 1'b1, 1'b0},
        {8'h85, 8'h13, 1'b0, 1'b0, 4'h5, 5'h13, 1'b0, 1'b1},
        {8'h85, 8'h13, 1'b0, 1'b1, 4'h5, 5'h13, 1'b1, 1'b1},
        {8'h0A, 8'h0E, 1'b1, 1'b1, 4'hF, 5'h0E, 1'b1, 1'b1},
        {8'h8A, 8'h2E, 1'b0, 1'b0, 4'hA, 5'h0E, 1'b0, 1'b1},
        {8'h7F, 8'hC0, 1'b0, 1'b0, 4'hF, 5'h00, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic [3:0] e_ram,
                             input logic [4:0] e_rom, input logic e_rcs,
                             input logic e_ocs);
        chk(req, "ram_bank", {4'h0, ram_bank}, {4'h0, e_ram});
        chk(req, "rom_bank", {3'h0, rom_bank}, {3'h0, e_rom});
        chk(req, "ram_cs_n", {7'h0, ram_cs_n}, {7'h0, e_rcs});
        chk(req, "rom_cs_n", {7'h0, rom_cs_n}, {7'h0, e_ocs});
    endtask

    // One-cycle write; returns just after the following falling edge.
    task automatic wr_cfg(input bit to_ram, input bit to_rom, input logic [7:0] v);
        @(negedge clk);
        data_in    = v;
        ram_cfg_wr = to_ram;
        rom_cfg_wr = to_rom;
        @(negedge clk);
        ram_cfg_wr = 1'b0;
        rom_cfg_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mreq_n = 1'b0;
        cpu_a15 = 1'b0;
        #1;
        // R1: reset state, overlay active, banks zero
        check_all("R1", 4'h0, 5'h00, 1'b1, 1'b0);

        // Table: R2 R3 R4 R5 R6 R7 R8 mapping patterns
        for (int i = 0; i < NV; i++) begin
            logic [28:0] v;
            v = VEC[i];
            wr_cfg(1'b1, 1'b0, v[28:21]);
            wr_cfg(1'b0, 1'b1, v[20:13]);
            cpu_a15 = v[12];
            mreq_n  = v[11];
            #1;
            check_all("R5/R6/R7 table", v[10:7], v[6:2], v[1], v[0]);
        end

        // R2: RAM register holds while strobe low
        cpu_a15 = 1'b0; mreq_n = 1'b0;
        wr_cfg(1'b1, 1'b0, 8'h85);
        data_in = 8'h00;
        repeat (3) @(negedge clk);
        #1;
        check_all("R2 hold", 4'h5, 5'h00, 1'b0, 1'b1);

        // R9: write during live request; old mapping until the edge
        @(negedge clk);
        data_in = 8'h03;
        ram_cfg_wr = 1'b1;
        #1;
        check_all("R9 before edge", 4'h5, 5'h00, 1'b0, 1'b1);
        @(negedge clk);
        ram_cfg_wr = 1'b0;
        #1;
        check_all("R9 after edge", 4'h3, 5'h00, 1'b1, 1'b0);

        // R9: both registers written from one byte in the same cycle
        wr_cfg(1'b1, 1'b1, 8'h9C);
        #1;
        check_all("R9 dual write", 4'hC, 5'h1C, 1'b0, 1'b1);

        // R8: no request idles both selects
        mreq_n = 1'b1;
        #1;
        check_all("R8 idle", 4'hC, 5'h1C, 1'b1, 1'b1);

        // R1: reset wins over a pending write
        @(negedge clk);
        rst_n = 1'b0;
        data_in = 8'hFF;
        ram_cfg_wr = 1'b1;
        rom_cfg_wr = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        ram_cfg_wr = 1'b0;
        rom_cfg_wr = 1'b0;
        mreq_n = 1'b0;
        #1;
        check_all("R1 reset over write", 4'h0, 5'h00, 1'b1, 1'b0);

        // R4: upper window after reset
        cpu_a15 = 1'b1;
        #1;
        check_all("R4 upper", 4'hF, 5'h00, 1'b0, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule